// File: doc/BRIEF.md
# Serial-Parallel Open-Drain Port Expander

This block gives a host a 24-bit bidirectional pin bank over a three-wire serial link: an active-low chip select, a shift clock, and a data line in each direction. The host opens a frame by pulling chip select low. At that moment the block takes a snapshot of the parallel pins and sends it out MSB first, one bit per shift clock. While it does so, it collects the host's 24 incoming bits into a second, independent shift register. When chip select returns high, the collected word moves into an output latch. Each latch bit controls one open-drain pin driver.

Each pin is modelled as a pull-down driver that is active when its latch bit is 0. Writing a 1 releases the pin so that an external source can drive it, and the pin then works as an input. The snapshot taken at the start of a frame is the external level ANDed with the latch bit. Clocks after the 24th in a frame are discarded, and the serial output is switched off for the rest of the frame. An active-low release input returns every pin and the serial output to the released state.

The link inputs and the pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and its edges are detected in the system clock domain. The serial link must therefore hold each level for at least four system clocks.

Top module: `sx_expander`

## Requirements
- R1: On the falling edge of `cs_n`, the block loads `pin_ext & latch` into the readout register. `latch` is the output latch, where bit 23 is pin 23.
- R2: While a frame is active, `sdo` first shows readout bit 23. Each falling edge of `sclk` advances `sdo` to the next lower bit.
- R3: On each of the first 24 rising edges of `sclk` in a frame, `sdi` is shifted into the collect register at bit 0, moving earlier bits toward bit 23. After 24 clocks, the first bit sent is in bit 23.
- R4: On the rising edge of `cs_n`, the collect register is copied to the latch. `pin_drive_low` equals the bitwise inverse of the latch, and the latch holds its value at all other times.
- R5: From the 25th rising edge of `sclk` in a frame onward, no serial bit is written and the latch result is unaffected.
- R6: From the 25th rising edge of `sclk` until the frame ends, `sdo_en` is 0.
- R7: If `cs_n` rises after fewer than 24 clocks, the latch takes the collect register as it stands. That value is the previous contents shifted left once for each received bit.
- R8: While `rel_n` is low, the latch is forced to all ones (`pin_drive_low` is 0) and `sdo_en` is 0.
- R9: While `cs_n` is high, `sdo_en` is 0.
- R10: After reset, the latch and the collect register are all ones, `pin_drive_low` is 0, and `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data from host |
| rel_n | input | 1 | Release all outputs, active low |
| pin_ext | input | 24 | Level driven onto the pins from outside |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Serial output enable; 0 means high impedance |
| pin_drive_low | output | 24 | Per-pin open-drain pull-down enable |

## Verification
A wrong bit in the readout register appears on `sdo` at the shift clock that reaches that bit, so it is visible within the same frame. A fault in the collect register or the bit counter is hidden until `cs_n` rises. It then shows as a wrong `pin_drive_low` pattern a few system clocks later. A counter that fails to saturate shows in two ways. The latch ends up shifted in frames longer than 24 clocks, and `sdo_en` stays high on the 26th clock.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned DEF_WIDTH   = 24;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sx_sync.sv
module sx_sync #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sx_tx.sv
module sx_tx #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] cap,
  output logic         msb
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= cap;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign msb = sh[W-1];
endmodule

// File: rtl/sx_rx.sv
module sx_rx #(
  parameter int unsigned W  = 24,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rise,
  input  logic          sdi,
  output logic [W-1:0]  data,
  output logic [CW-1:0] cnt,
  output logic          over
);
  localparam logic [CW-1:0] LAST = CW'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '1;
      cnt  <= '0;
      over <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      over <= 1'b0;
    end else if (rise) begin
      if (cnt == LAST) begin
        over <= 1'b1;
      end else begin
        data <= {data[W-2:0], sdi};
        cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sx_expander.sv
module sx_expander
  import sx_pkg::*;
#(
  parameter int unsigned W  = DEF_WIDTH,
  parameter int unsigned SS = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         rel_n,
  input  logic [W-1:0] pin_ext,
  output logic         sdo,
  output logic         sdo_en,
  output logic [W-1:0] pin_drive_low
);
  localparam int unsigned CW = cnt_bits(W);

  logic [3:0]   ctl_s;
  logic [W-1:0] pin_s;
  logic         rel_s, cs_s, sclk_s, sdi_s;
  logic         cs_d, sclk_d;
  logic         cs_low, cs_fall, cs_rise, clk_rise, clk_fall;
  logic [W-1:0] latch, rx_data, cap;
  logic [CW-1:0] rx_cnt;
  logic         rx_over, tx_msb, en_q;

  sx_sync #(.N(4), .STAGES(SS), .RST_VAL(4'b1100)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({rel_n, cs_n, sclk, sdi}), .q(ctl_s)
  );
  sx_sync #(.N(W), .STAGES(SS), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_ext), .q(pin_s)
  );

  assign {rel_s, cs_s, sclk_s, sdi_s} = ctl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_low   = ~cs_s;
  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign clk_rise = ~sclk_d & sclk_s & cs_low;
  assign clk_fall = sclk_d & ~sclk_s & cs_low;
  assign cap      = pin_s & latch;

  sx_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .load(cs_fall),
    .shift(clk_fall & ~rx_over), .cap(cap), .msb(tx_msb)
  );

  sx_rx #(.W(W), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .start(cs_fall), .rise(clk_rise), .sdi(sdi_s),
    .data(rx_data), .cnt(rx_cnt), .over(rx_over)
  );

  always_ff @(posedge clk) begin
    if (rst)          latch <= '1;
    else if (!rel_s)  latch <= '1;
    else if (cs_rise) latch <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= rel_s & cs_low & ~rx_over;
  end

  assign sdo           = tx_msb;
  assign sdo_en        = en_q;
  assign pin_drive_low = ~latch;
endmodule

// File: rtl/sx_expander_chk.sv
module sx_expander_chk #(
  parameter int unsigned W  = 24,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_low,
  input logic          cs_rise,
  input logic          clk_rise,
  input logic          rel_s,
  input logic [CW-1:0] rx_cnt,
  input logic [W-1:0]  rx_data,
  input logic [W-1:0]  latch,
  input logic          sdo_en,
  input logic [W-1:0]  pin_drive_low
);
  AST_CS_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
    !cs_low |=> !sdo_en); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !rel_s |=> (pin_drive_low == '0) && !sdo_en); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_rise && rel_s) |=> $stable(latch)); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(W)); // R5
  AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && rx_cnt == CW'(W)) |=> $stable(rx_data)); // R5
  AST_EN_DROP: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && rx_cnt == CW'(W)) |=> ##1 !sdo_en); // R6
endmodule

bind sx_expander sx_expander_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cs_low(cs_low), .cs_rise(cs_rise),
  .clk_rise(clk_rise), .rel_s(rel_s), .rx_cnt(rx_cnt), .rx_data(rx_data),
  .latch(latch), .sdo_en(sdo_en), .pin_drive_low(pin_drive_low)
);

// File: tb/tb_sx_expander.sv
module tb_sx_expander;
  localparam int W  = 24;
  localparam int PH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, rel_n = 1'b1;
  logic [W-1:0] pin_ext = '0;
  logic sdo, sdo_en;
  logic [W-1:0] pin_drive_low;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] latch_m = '1, rx_m = '1;

  typedef struct packed { logic en; logic bit_v; logic valid; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  sx_expander dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .rel_n(rel_n),
    .pin_ext(pin_ext), .sdo(sdo), .sdo_en(sdo_en), .pin_drive_low(pin_drive_low)
  );

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each shift clock rising edge pops one expected item
  always @(posedge sclk) begin
    item_t it;
    if (q.size() == 0) begin
      chk(1'b0, "scoreboard underflow", '0, '0);
    end else begin
      it = q.pop_front();
      if (it.valid) begin
        if (it.en) begin
          chk(sdo_en == 1'b1, "R1 R2 sdo_en in frame", W'(sdo_en), W'(1));
          chk(sdo == it.bit_v, "R1 R2 sdo bit", W'(sdo), W'(it.bit_v));
        end else begin
          chk(sdo_en == 1'b0, "R6 sdo_en after 25th clock", W'(sdo_en), W'(0));
        end
      end
    end
  end

  task automatic frame(input int nclk, input logic [W-1:0] wr, input logic [W-1:0] ext);
    logic [W-1:0] capt;
    pin_ext = ext;
    wait_clk(PH);
    capt = ext & latch_m;
    cs_n = 1'b0;
    wait_clk(PH);
    for (int k = 1; k <= nclk; k++) begin
      item_t it;
      sdi = (k <= W) ? wr[W-k] : 1'b1;
      if (k <= W) begin
        it = '{en: 1'b1, bit_v: capt[W-k], valid: 1'b1};
        rx_m = {rx_m[W-2:0], sdi};
      end else if (k == W + 1) begin
        it = '{en: 1'b0, bit_v: 1'b0, valid: 1'b0};
      end else begin
        it = '{en: 1'b0, bit_v: 1'b0, valid: 1'b1};
      end
      q.push_back(it);
      wait_clk(PH);
      sclk = 1'b1;
      wait_clk(PH);
      sclk = 1'b0;
      wait_clk(PH);
    end
    cs_n = 1'b1;
    latch_m = rx_m;
    wait_clk(PH);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R10 reset state
    chk(pin_drive_low == '0, "R10 pins released after reset", pin_drive_low, '0);
    chk(sdo_en == 1'b0, "R10 sdo_en after reset", W'(sdo_en), '0);
    // R9 idle
    wait_clk(PH);
    chk(sdo_en == 1'b0, "R9 sdo_en with cs high", W'(sdo_en), '0);

    // full frame, all pins released: R1 R2 R3 R4
    frame(W, 24'hA5C33C, 24'hFFFFFF);
    chk(pin_drive_low == ~latch_m, "R3 R4 latch after full frame", pin_drive_low, ~latch_m);
    chk(sdo_en == 1'b0, "R9 sdo_en after frame", W'(sdo_en), '0);

    // long frame, readback masked by latch: R1 R5 R6
    frame(W + 4, 24'h123456, 24'h0F0F0F);
    chk(pin_drive_low == ~24'h123456, "R5 extra clocks ignored", pin_drive_low, ~24'h123456);

    // readback of partly driven pins again
    frame(W, 24'hFF00F0, 24'hFFFFFF);
    chk(pin_drive_low == ~24'hFF00F0, "R4 latch pattern", pin_drive_low, ~24'hFF00F0);

    // short frame of 10 clocks: R7
    frame(10, 24'h2AB000, 24'hFFFFFF);
    chk(pin_drive_low == ~latch_m, "R7 short frame latch", pin_drive_low, ~latch_m);

    // release input during an open frame: R8
    cs_n = 1'b0;
    wait_clk(PH);
    rel_n = 1'b0;
    wait_clk(PH);
    chk(pin_drive_low == '0, "R8 pins released", pin_drive_low, '0);
    chk(sdo_en == 1'b0, "R8 sdo_en off", W'(sdo_en), '0);
    cs_n = 1'b1;
    wait_clk(PH);
    rel_n = 1'b1;
    latch_m = '1;
    wait_clk(PH);
    chk(pin_drive_low == '0, "R8 release persists", pin_drive_low, '0);

    // frame after release reads external levels directly: R1
    frame(W, 24'h00FF0F, 24'hC3C3C3);
    chk(pin_drive_low == ~24'h00FF0F, "R4 latch after release", pin_drive_low, ~24'h00FF0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule